// File: doc/BRIEF.md
# DRAM Strobe Cycle Classifier

This block is a passive observer placed beside an asynchronous DRAM bus. It watches the row strobe, the upper and lower column strobes, write enable and output enable, all active low, through a fast sampling clock. It never drives the bus. At the end of every row cycle it reports the kind of cycle it has seen, which byte lanes took part, and whether the two lanes disagreed about how they were used.

The cycle kind comes only from the order of the sampled strobe edges. Nanosecond limits are not checked. For choosing between refresh and access, the two column strobes act as one combined strobe: the cycle is active if either is low. For read and write decisions, each lane keeps its own record, taken from its own falling edge. The block can serve as a protocol checker in a testbench or as a snooper that labels bus traffic.

Every input passes through a two-flop synchroniser before any edge is detected. The sampling clock must be at least four times faster than the shortest strobe pulse or gap.

Top module: `strobe_cycle_classifier`

## Requirements
- R1: While reset is held, and in the first cycle after reset is released, `ev_valid`, `ev_kind`, `ev_hi`, `ev_lo` and `ev_err` are all 0.
- R2: When the synchronised row strobe rises, after a fall that the block has seen, `ev_valid` is 1 for exactly one clock. This happens on the third rising clock edge after the input change. The other outputs are valid only in that cycle and are 0 at all other times.
- R3: If the row strobe falls and rises again while both column strobes stay high, the report is kind 5 (row-only refresh) with both lane flags at 0.
- R4: If at least one column strobe is already low when the row strobe falls, and no read has left a column strobe held low, the report is kind 6 (column-first refresh). The lane flags show which column strobes were low at that fall.
- R5: An access in which every active lane fell with write enable high, and write enable never fell afterwards, is reported as kind 1 (read).
- R6: If a lane's first falling edge in the row cycle finds write enable low, that lane is an early write. Any early-write lane makes the report kind 2.
- R7: A lane that fell as a read becomes a late write if write enable falls while that lane is still low. With no early lane, and with output enable not seen low before the write, the report is kind 3 (delayed write).
- R8: If output enable was low while a column strobe was low, and is high again when write enable falls, a late write is reported as kind 4 (read-modify-write).
- R9: Suppose a read ends with a column strobe still held low, and the row strobe then falls again before both column strobes go high. That next cycle is reported as kind 7 (hidden refresh), with lane flags taken from the held strobes. Releasing both column strobes clears this condition.
- R10: In an access cycle, `ev_hi` and `ev_lo` are 1 exactly for the lanes whose column strobe fell at least once while the row strobe was low. This includes lanes that toggle one after the other within one row cycle.
- R11: `ev_err` is 1 when both lanes were active and their modes (read, early write, late write) differ. It is always 0 for refresh cycles and for single-lane cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| row_n | input | 1 | Row strobe, active low, asynchronous |
| colhi_n | input | 1 | Upper-byte column strobe, active low |
| collo_n | input | 1 | Lower-byte column strobe, active low |
| wr_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| ev_valid | output | 1 | One-cycle pulse marking a finished row cycle |
| ev_kind | output | 3 | Cycle kind code (1 to 7, as listed in the requirements) |
| ev_hi | output | 1 | Upper lane took part |
| ev_lo | output | 1 | Lower lane took part |
| ev_err | output | 1 | The two lanes used conflicting modes |

## Verification
A mode conflict between the lanes and a write classification can land in the same report. The bench provokes this by starting the upper lane as an early write and then late-writing the lower lane in the same row cycle. It expects an early-write kind with both lane flags and the error flag set, all in one pulse. A second overlap joins the end of a read with the start of a hidden refresh: the column strobes stay low across the row precharge. The bench checks that the read is reported as a read, and that the following cycle is reported as a hidden refresh rather than a column-first refresh.

// File: rtl/scc_pkg.sv
`timescale 1ns/1ps
// Shared types for the strobe cycle classifier.
package scc_pkg;
    // Cycle kind codes reported on ev_kind.
    typedef enum logic [2:0] {
        K_NONE    = 3'd0,
        K_READ    = 3'd1,
        K_EARLYWR = 3'd2,
        K_LATEWR  = 3'd3,
        K_RMW     = 3'd4,
        K_ROWREF  = 3'd5,
        K_COLREF  = 3'd6,
        K_HIDREF  = 3'd7
    } kind_e;

    // Per-lane usage within one row cycle.
    typedef enum logic [1:0] {
        LM_IDLE  = 2'd0,
        LM_READ  = 2'd1,
        LM_EARLY = 2'd2,
        LM_LATE  = 2'd3
    } lane_mode_e;
endpackage

// File: rtl/scc_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser for a vector of asynchronous inputs.
// Assumes each bit is independent; resets to RST_VAL (inactive level).
module scc_sync #(
    parameter int              W       = 5,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage captures the raw asynchronous inputs.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= RST_VAL;
                else        chain[g] <= din;
            end
        end else begin : g_next
            // Later stages settle metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= RST_VAL;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/scc_edges.sv
`timescale 1ns/1ps
// Edge detector on synchronised levels. rise = 0->1, fall = 1->0.
// Assumes inputs are already synchronous to clk.
module scc_edges #(
    parameter int           W       = 5,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev;

    // Remember last sampled level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= RST_VAL;
        else        prev <= lvl;
    end

    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;
endmodule

// File: rtl/scc_lane.sv
`timescale 1ns/1ps
// Byte-lane mode tracker. The mode is fixed by the lane's first falling
// edge in a row cycle; a read lane upgrades to a late write when write
// enable falls while the lane is low. Assumes synchronised inputs.
module scc_lane
    import scc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       active,
    input  logic       col_fall,
    input  logic       col_low,
    input  logic       wr_low,
    input  logic       wr_fall,
    output lane_mode_e mode
);
    // Track the lane's usage across one row cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            mode <= LM_IDLE;
        end else if (active) begin
            if (col_fall && mode == LM_IDLE)
                mode <= wr_low ? LM_EARLY : LM_READ;
            else if (wr_fall && col_low && mode == LM_READ)
                mode <= LM_LATE;
        end
    end
endmodule

// File: rtl/strobe_cycle_classifier.sv
`timescale 1ns/1ps
// Passive classifier of asynchronous DRAM strobe cycles. Synchronises the
// five strobes, detects edges and reports the kind of each row cycle with
// lane flags and a lane-conflict flag in a one-cycle pulse after the row
// strobe rises. Assumes the clock is at least 4x faster than any pulse.
module strobe_cycle_classifier
    import scc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       row_n,
    input  logic       colhi_n,
    input  logic       collo_n,
    input  logic       wr_n,
    input  logic       oe_n,
    output logic       ev_valid,
    output logic [2:0] ev_kind,
    output logic       ev_hi,
    output logic       ev_lo,
    output logic       ev_err
);
    localparam int NSIG  = 5;
    localparam int NLANE = 2;
    localparam int B_ROW = 0, B_CHI = 1, B_CLO = 2, B_WR = 3, B_OE = 4;

    logic [NSIG-1:0] raw, lvl, rise, fall;
    assign raw = {oe_n, wr_n, collo_n, colhi_n, row_n};

    scc_sync #(.W(NSIG), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(raw), .dout(lvl));

    scc_edges #(.W(NSIG), .RST_VAL('1)) u_edges (
        .clk(clk), .rst_n(rst_n), .lvl(lvl), .rise(rise), .fall(fall));

    logic row_fall, row_rise, wr_low, wr_fall, oe_low;
    logic [NLANE-1:0] col_low, col_fall;
    assign row_fall = fall[B_ROW];
    assign row_rise = rise[B_ROW];
    assign wr_low   = ~lvl[B_WR];
    assign wr_fall  = fall[B_WR];
    assign oe_low   = ~lvl[B_OE];
    assign col_low  = {~lvl[B_CHI], ~lvl[B_CLO]};
    assign col_fall = {fall[B_CHI], fall[B_CLO]};

    logic             row_open, in_ref, hold_read, oe_seen, rmw_seen;
    kind_e            ref_kind;
    logic [NLANE-1:0] ref_lanes;
    logic             access_on, lane_start;
    assign access_on  = row_open & ~in_ref;
    assign lane_start = row_fall;

    lane_mode_e lmode [NLANE];
    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        scc_lane u_lane (
            .clk(clk), .rst_n(rst_n), .start(lane_start), .active(access_on),
            .col_fall(col_fall[l]), .col_low(col_low[l]),
            .wr_low(wr_low), .wr_fall(wr_fall), .mode(lmode[l]));
    end

    // Decide the report of the cycle now closing.
    kind_e            nx_kind;
    logic [NLANE-1:0] nx_lanes;
    logic             nx_err, any_early, any_late;
    always_comb begin
        any_early = 1'b0;
        any_late  = 1'b0;
        for (int l = 0; l < NLANE; l++) begin
            nx_lanes[l] = (lmode[l] != LM_IDLE);
            any_early   = any_early | (lmode[l] == LM_EARLY);
            any_late    = any_late  | (lmode[l] == LM_LATE);
        end
        nx_err = (&nx_lanes) && (lmode[1] != lmode[0]);
        if (in_ref) begin
            nx_kind  = ref_kind;
            nx_lanes = ref_lanes;
            nx_err   = 1'b0;
        end else if (nx_lanes == '0) nx_kind = K_ROWREF;
        else if (any_early)          nx_kind = K_EARLYWR;
        else if (any_late)           nx_kind = rmw_seen ? K_RMW : K_LATEWR;
        else                         nx_kind = K_READ;
    end

    // Cycle bookkeeping and registered report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_open  <= 1'b0;
            in_ref    <= 1'b0;
            hold_read <= 1'b0;
            oe_seen   <= 1'b0;
            rmw_seen  <= 1'b0;
            ref_kind  <= K_COLREF;
            ref_lanes <= '0;
            ev_valid  <= 1'b0;
            ev_kind   <= K_NONE;
            ev_hi     <= 1'b0;
            ev_lo     <= 1'b0;
            ev_err    <= 1'b0;
        end else begin
            ev_valid <= 1'b0;
            ev_kind  <= K_NONE;
            ev_hi    <= 1'b0;
            ev_lo    <= 1'b0;
            ev_err   <= 1'b0;
            if (col_low == '0) hold_read <= 1'b0;
            if (row_fall) begin
                row_open  <= 1'b1;
                in_ref    <= |col_low;
                ref_lanes <= col_low;
                ref_kind  <= hold_read ? K_HIDREF : K_COLREF;
                oe_seen   <= 1'b0;
                rmw_seen  <= 1'b0;
            end else if (access_on) begin
                if (oe_low && |col_low) oe_seen <= 1'b1;
                if (wr_fall && |col_low && oe_seen && !oe_low) rmw_seen <= 1'b1;
            end
            if (row_rise && row_open) begin
                row_open <= 1'b0;
                in_ref   <= 1'b0;
                ev_valid <= 1'b1;
                ev_kind  <= nx_kind;
                ev_hi    <= nx_lanes[1];
                ev_lo    <= nx_lanes[0];
                ev_err   <= nx_err;
                if ((nx_kind == K_READ || nx_kind == K_HIDREF) && |col_low)
                    hold_read <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/scc_checker.sv
`timescale 1ns/1ps
// Property checker for the strobe cycle classifier, bound to the top.
module scc_checker
    import scc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       ev_valid,
    input logic [2:0] ev_kind,
    input logic       ev_hi,
    input logic       ev_lo,
    input logic       ev_err,
    input logic       row_rise
);
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |=> !ev_valid);

    a_r2_follows_row_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |-> $past(row_rise));

    a_r3_row_only_no_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_kind == K_ROWREF) |-> (!ev_hi && !ev_lo));

    a_r4_refresh_has_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && (ev_kind == K_COLREF || ev_kind == K_HIDREF)) |-> (ev_hi || ev_lo));

    a_r11_err_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
        ev_err |-> (ev_valid && ev_hi && ev_lo && ev_kind != K_COLREF && ev_kind != K_HIDREF));

    a_r2_quiet_fields: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_valid |-> (ev_kind == K_NONE && !ev_hi && !ev_lo && !ev_err));
endmodule

bind strobe_cycle_classifier scc_checker u_chk (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
    .ev_hi(ev_hi), .ev_lo(ev_lo), .ev_err(ev_err), .row_rise(row_rise));

// File: tb/strobe_cycle_classifier_test.sv
`timescale 1ns/1ps
module strobe_cycle_classifier_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic row_n = 1'b1, colhi_n = 1'b1, collo_n = 1'b1, wr_n = 1'b1, oe_n = 1'b1;
    logic ev_valid, ev_hi, ev_lo, ev_err;
    logic [2:0] ev_kind;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    strobe_cycle_classifier uut (
        .clk(clk), .rst_n(rst_n), .row_n(row_n), .colhi_n(colhi_n),
        .collo_n(collo_n), .wr_n(wr_n), .oe_n(oe_n), .ev_valid(ev_valid),
        .ev_kind(ev_kind), .ev_hi(ev_hi), .ev_lo(ev_lo), .ev_err(ev_err));

    // Vector: [15:12] pattern, [11:9] kind, [8] hi, [7] lo, [6] err
    localparam int NV = 9;
    localparam logic [15:0] VEC [NV] = '{
        {4'd0, 3'd1, 1'b1, 1'b1, 1'b0, 6'd0},  // R5 word read
        {4'd1, 3'd1, 1'b0, 1'b1, 1'b0, 6'd0},  // R10 lower read
        {4'd2, 3'd2, 1'b1, 1'b0, 1'b0, 6'd0},  // R6 upper early write
        {4'd3, 3'd3, 1'b1, 1'b1, 1'b0, 6'd0},  // R7 delayed write
        {4'd4, 3'd4, 1'b1, 1'b1, 1'b0, 6'd0},  // R8 read-modify-write
        {4'd5, 3'd5, 1'b0, 1'b0, 1'b0, 6'd0},  // R3 row-only refresh
        {4'd6, 3'd6, 1'b1, 1'b0, 1'b0, 6'd0},  // R4 column-first refresh
        {4'd7, 3'd2, 1'b1, 1'b1, 1'b1, 6'd0},  // R11 mixed lane modes
        {4'd8, 3'd1, 1'b1, 1'b1, 1'b0, 6'd0}   // R10 staggered lanes
    };

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Raise the row strobe and check the pulse and its fields.
    task automatic end_row(input string req, input int kind, input int hi,
                           input int lo, input int err);
        row_n = 1'b1;
        tick(3);
        check({req, " valid"}, ev_valid, 1);
        check({req, " kind"}, ev_kind, kind);
        check({req, " hi"}, ev_hi, hi);
        check({req, " lo"}, ev_lo, lo);
        check({req, " err"}, ev_err, err);
        tick(1);
        check("R2 pulse ends", ev_valid, 0);
        tick(3);
    endtask

    task automatic run_pat(input int p);
        case (p)
            0: begin oe_n = 0; row_n = 0; tick(4); colhi_n = 0; collo_n = 0; tick(4); end
            1: begin oe_n = 0; row_n = 0; tick(4); collo_n = 0; tick(4); end
            2: begin row_n = 0; tick(4); wr_n = 0; tick(4); colhi_n = 0; tick(4); end
            3: begin row_n = 0; tick(4); colhi_n = 0; collo_n = 0; tick(4); wr_n = 0; tick(4); end
            4: begin oe_n = 0; row_n = 0; tick(4); colhi_n = 0; collo_n = 0; tick(4);
                     oe_n = 1; tick(4); wr_n = 0; tick(4); end
            5: begin row_n = 0; tick(8); end
            6: begin colhi_n = 0; tick(4); row_n = 0; tick(4); end
            7: begin row_n = 0; tick(4); wr_n = 0; tick(4); colhi_n = 0; tick(4);
                     wr_n = 1; tick(4); collo_n = 0; tick(4); wr_n = 0; tick(4); end
            8: begin oe_n = 0; row_n = 0; tick(4); collo_n = 0; tick(4); collo_n = 1; tick(4);
                     colhi_n = 0; tick(4); colhi_n = 1; tick(4); end
            default: ;
        endcase
        colhi_n = 1; collo_n = 1; wr_n = 1; oe_n = 1;
        tick(4);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(4);
        check("R1 reset valid", ev_valid, 0);
        check("R1 reset kind", ev_kind, 0);
        rst_n = 1'b1;
        tick(1);
        check("R1 after reset valid", ev_valid, 0);
        check("R1 after reset flags", {ev_hi, ev_lo, ev_err}, 0);
        tick(4);

        for (int i = 0; i < NV; i++) begin
            run_pat(int'(VEC[i][15:12]));
            end_row($sformatf("vector %0d (R2..R11)", i), int'(VEC[i][11:9]),
                    int'(VEC[i][8]), int'(VEC[i][7]), int'(VEC[i][6]));
        end

        // R9: read with column strobes held low, then hidden refresh.
        oe_n = 0; row_n = 0; tick(4);
        colhi_n = 0; collo_n = 0; tick(4);
        end_row("R9 read before hidden", 1, 1, 1, 0);
        row_n = 0; tick(4);
        end_row("R9 hidden refresh", 7, 1, 1, 0);
        colhi_n = 1; collo_n = 1; oe_n = 1; tick(4);

        // R4: hold cleared by release; lower-only column-first refresh.
        collo_n = 0; tick(4);
        row_n = 0; tick(4);
        end_row("R4 after release", 6, 0, 1, 0);
        collo_n = 1; tick(4);

        // R2: a row cycle still open produces no pulse.
        row_n = 0; tick(8);
        check("R2 no pulse while row low", ev_valid, 0);
        end_row("R3 idle row", 5, 0, 0, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule